// File: doc/BRIEF.md
# Word-Addressed Bit Memory with Serial OR Readout

This block is a small random access memory: by default four words of one bit each, with the word width set by a parameter. An address is decoded into one row-enable line per word. Every stored bit sits in a cell that updates through a three-input majority vote. The vote takes the cell's present value, a data term gated by the write control and a feedback term gated by the read control. During a read the vote returns the old value. During a write it returns the input bit.

Read data is not shared over a tristate bus or picked by a multiplexer. Each cell drives a read term that is 0 unless it is selected and being read. These terms are combined through a serial OR chain that runs from the first row to the last. The chain result is registered once, so read data and its valid flag appear one clock after the request.

Top module: `bitmem_or_chain`

## Requirements
- R1: When `csel`=1 and `wr_nrd`=1 at a rising clock edge, the word at row index `addr` (read as an unsigned binary number) takes the value of `din`. A later read of that address returns it.
- R2: When `csel`=1 and `wr_nrd`=0, the addressed word is not changed. Two reads of the same address in a row return equal data.
- R3: When `csel`=0, no word changes, whatever `addr`, `din` and `wr_nrd` are.
- R4: For any address, exactly one row-enable line is active while `csel`=1 and none is active while `csel`=0. A write changes only the addressed word.
- R5: `dout_vld` is 1 in exactly the cycle after a read request (`csel`=1, `wr_nrd`=0). In that cycle `dout` holds the word that was addressed.
- R6: `dout` is all zeros whenever `dout_vld` is 0, which covers the cycle after a write and the cycle after a deselected cycle.
- R7: A clock edge with `rst_n`=0 clears every word to 0 and drives `dout` and `dout_vld` to 0.
- R8: The bits of a word are stored independently. With `WORD_W`>1, each bit position reads back the bit written at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word index |
| din | input | WORD_W | Write data |
| wr_nrd | input | 1 | 1 = write, 0 = read |
| csel | input | 1 | Chip select, active high |
| dout | output | WORD_W | Registered read data, zero when not valid |
| dout_vld | output | 1 | High for the cycle that carries read data |

## Verification
On every cycle the assertions check three things: the row enables are one-hot while the block is selected and idle while it is not; the valid flag follows a read request by one cycle with zero data otherwise; and reset clears the outputs. They also check, on any cycle where the pattern occurs, two back-to-back sequences: a write followed by a read of the same address returns the written data, and two reads of the same address return equal data. The bench's scenarios, checked against a reference array, are what show that every other word keeps its value. They also cover deselected write attempts that leave every word intact, reset clearing stored contents, and independent bit positions in a wider word.

// File: rtl/bitmem_pkg.sv
// Shared helpers for the word-addressed bit memory.
// Assumes: nothing beyond single-bit logic values.
package bitmem_pkg;

    // Three-input majority vote.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/bitmem_row_decode.sv
// Row decoder: one AND term per row over true or inverted address bits.
// Assumes: addr is a plain binary index; output is one-hot for every address.
module bitmem_row_decode #(
    parameter int ADDR_W = 2,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  row
);
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        localparam logic [ADDR_W-1:0] RV = ADDR_W'(r);
        logic [ADDR_W-1:0] lit;
        for (genvar b = 0; b < ADDR_W; b++) begin : g_lit
            // purpose: choose true or inverted address bit for this row
            assign lit[b] = RV[b] ? addr[b] : ~addr[b];
        end
        // purpose: AND of all literals forms the row line
        assign row[r] = &lit;
    end
endmodule

// File: rtl/bitmem_cell.sv
// One storage bit. The next value is a majority of the present value, a
// write-gated data term and a read-gated feedback term. The read term is
// nonzero only while the cell is selected and read.
// Assumes: sel already includes chip select.
module bitmem_cell
    import bitmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wr,
    input  logic d,
    output logic rd_term
);
    logic q;
    logic t_data;
    logic t_fb;
    logic q_next;

    // purpose: form the majority inputs and the vote result
    always_comb begin
        t_data = wr & d;
        t_fb   = ~wr | ~q;
        q_next = maj3(q, t_data, t_fb);
    end

    // purpose: store the vote only while selected; synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (sel) q <= q_next;
    end

    // purpose: contribute to the OR chain only during a selected read
    assign rd_term = sel & ~wr & q_next;
endmodule

// File: rtl/bitmem_or_chain_link.sv
// Serial OR chain: folds the read terms from row 0 to row N-1.
// Assumes: at most one input is nonzero, so OR gives that input's value.
module bitmem_or_chain_link #(
    parameter int N = 4
) (
    input  logic [N-1:0] taps,
    output logic         merged
);
    logic [N:0] link;
    assign link[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_link
        // purpose: extend the chain by one row
        assign link[i+1] = link[i] | taps[i];
    end
    assign merged = link[N];
endmodule

// File: rtl/bitmem_or_chain.sv
// Top: DEPTH x WORD_W memory of majority cells with a decoder, per-bit OR
// chains and a one-cycle registered read port.
// Assumes: synchronous active-low reset; inputs stable around clk rise.
module bitmem_or_chain #(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic              wr_nrd,
    input  logic              csel,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]             row_raw;
    logic [DEPTH-1:0]             row_hit;
    logic [WORD_W-1:0][DEPTH-1:0] taps;
    logic [WORD_W-1:0]            chain_out;

    bitmem_row_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .row  (row_raw)
    );

    // purpose: gate every row line with chip select
    assign row_hit = row_raw & {DEPTH{csel}};

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        for (genvar r = 0; r < DEPTH; r++) begin : g_row
            bitmem_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel     (row_hit[r]),
                .wr      (wr_nrd),
                .d       (din[b]),
                .rd_term (taps[b][r])
            );
        end
        bitmem_or_chain_link #(.N(DEPTH)) u_chain (
            .taps   (taps[b]),
            .merged (chain_out[b])
        );
    end

    // purpose: register chain result and read-valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout     <= chain_out;
            dout_vld <= csel & ~wr_nrd;
        end
    end
endmodule

// File: rtl/bitmem_chk.sv
// Property checker for bitmem_or_chain, attached by bind.
// Assumes: observes ports plus the gated row lines.
module bitmem_chk #(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] din,
    input logic              wr_nrd,
    input logic              csel,
    input logic [WORD_W-1:0] dout,
    input logic              dout_vld,
    input logic [DEPTH-1:0]  row_hit
);
    assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csel |-> $countones(row_hit) == 1);

    assert_row_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |-> row_hit == '0);

    assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csel && !wr_nrd) |=> dout_vld);

    assert_quiet_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(csel && !wr_nrd) |=> (!dout_vld && dout == '0));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!dout_vld && dout == '0));

    assert_write_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csel && wr_nrd) ##1 (csel && !wr_nrd && addr == $past(addr))
        |=> dout == $past(din, 2));

    assert_read_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csel && !wr_nrd) ##1 (csel && !wr_nrd && addr == $past(addr))
        |=> dout == $past(dout));
endmodule

bind bitmem_or_chain bitmem_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .din      (din),
    .wr_nrd   (wr_nrd),
    .csel     (csel),
    .dout     (dout),
    .dout_vld (dout_vld),
    .row_hit  (row_hit)
);

// File: tb/tb_bitmem_or_chain.sv
// Directed bench for bitmem_or_chain with a reference word array.
module tb_bitmem_or_chain;
    localparam int AW = 2;
    localparam int W  = 2;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic          wr_nrd = 1'b0;
    logic          csel = 1'b0;
    logic [W-1:0]  dout;
    logic          dout_vld;

    logic [W-1:0]  ref_mem [D];
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bitmem_or_chain #(.ADDR_W(AW), .WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .wr_nrd(wr_nrd), .csel(csel), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); din = W'(d); wr_nrd = 1'b1; csel = 1'b1;
        @(negedge clk);
        chk("R6 write gives zero out", int'({dout_vld, dout}), 0);
        ref_mem[a] = W'(d);
        csel = 1'b0;
    endtask

    task automatic do_read(input int a, input string req);
        @(negedge clk);
        addr = AW'(a); wr_nrd = 1'b0; csel = 1'b1;
        @(negedge clk);
        chk({req, " data"}, int'(dout), int'(ref_mem[a]));
        chk("R5 valid after read", int'(dout_vld), 1);
        csel = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; csel = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 outputs cleared", int'({dout_vld, dout}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < D; i++) ref_mem[i] = '0;
    endtask

    task automatic t_reset_state();
        apply_reset();
        for (int i = 0; i < D; i++) do_read(i, "R7 cleared word");
    endtask

    task automatic t_write_all();
        for (int i = 0; i < D; i++) do_write(i, (i + 1) % (1 << W));
        for (int i = D - 1; i >= 0; i--) do_read(i, "R1 written word");
        do_write(2, 0);
        do_read(2, "R1 overwrite to zero");
    endtask

    task automatic t_read_hold();
        do_write(1, 3);
        for (int k = 0; k < 3; k++) do_read(1, "R2 repeated read");
    endtask

    task automatic t_deselect();
        @(negedge clk);
        csel = 1'b0; wr_nrd = 1'b1;
        for (int i = 0; i < D; i++) begin
            addr = AW'(i); din = ~ref_mem[i];
            @(negedge clk);
            chk("R3 deselected out", int'({dout_vld, dout}), 0);
        end
        for (int i = 0; i < D; i++) do_read(i, "R3 word unchanged");
    endtask

    task automatic t_neighbors();
        for (int i = 0; i < D; i++) do_write(i, 0);
        do_write(3, 2);
        for (int i = 0; i < D; i++) do_read(i, "R4 only addressed row");
        do_write(0, 1);
        for (int i = 0; i < D; i++) do_read(i, "R4 only addressed row");
    endtask

    task automatic t_bits();
        do_write(2, 1);
        do_read(2, "R8 low bit only");
        do_write(2, 2);
        do_read(2, "R8 high bit only");
    endtask

    task automatic t_reset_contents();
        for (int i = 0; i < D; i++) do_write(i, 3);
        apply_reset();
        for (int i = 0; i < D; i++) do_read(i, "R7 reset clears stored");
    endtask

    initial begin
        for (int i = 0; i < D; i++) ref_mem[i] = '0;
        t_reset_state();
        t_write_all();
        t_read_hold();
        t_deselect();
        t_neighbors();
        t_bits();
        t_reset_contents();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule